// File: doc/BRIEF.md
# Circular Trace Capture Buffer

This block collects a stream of 32-bit trace words into an internal RAM. Software runs it through a small register port made of an address, a write-data bus, a write enable and a read strobe. There are two operating modes. In circular mode the RAM is filled without backpressure, and once the write pointer passes the end of the RAM the oldest words are overwritten. After capture is stopped, software drains the stored words by reading one data register again and again. In FIFO mode the RAM acts as a pass-through queue between the trace input and an output stream with ready/valid handshake.

Capture starts when the control bit is set and stops when it is cleared. A stop in FIFO mode first waits for the queue to empty. In circular mode a trigger input can also stop capture by itself: after the trigger, a programmed number of further words is kept and then capture halts. Software can move the read pointer to a frame-aligned position to read only the most recent part of the buffer. The status register shows an idle/ready bit, a sticky wrap ("full") bit and a triggered bit.

Register word addresses: 0 control (bit 0 capture enable; reads 1 while capturing), 1 mode (bit 0: 0 = circular, 1 = FIFO), 2 trigger count, 3 read data, 4 read pointer (byte address), 5 write pointer (byte address, read only), 6 status (bit 0 ready, bit 1 full, bit 2 triggered). The parameter DEPTH must be a power of two and at least 16.

Top module: `trace_capture_buf`

## Requirements
- R1: After reset the status reads 1 (ready, not full, not triggered), the mode reads 0, both pointers read 0, and a read of the data register returns 0xFFFFFFFF.
- R2: In circular mode, once capture is stopped, each strobed read of address 3 returns the next stored word, oldest first, and advances the read pointer. When no words remain it returns 0xFFFFFFFF.
- R3: Writing DEPTH or more words in circular mode sets status bit 1. The bit stays set until the next start. Readout then returns exactly the last DEPTH words, oldest first.
- R4: Writing 0 to control bit 0 stops circular capture, and status bit 0 reads 1 on the next cycle. While stopped, trace words are ignored: the write pointer and the readout do not change.
- R5: A write to the read pointer is accepted only while ready in circular mode. Byte-address bits [3:0] are forced to zero (bits [4:0] when MEM_BITS is 256). After the write, the readable words are those from the new pointer up to the write pointer.
- R6: The write pointer register reads the byte address of the next write, i.e. 4 × (words written mod DEPTH).
- R7: In circular mode with trigger count T, capture keeps exactly T words, starting with the word offered in the trigger cycle, and then stops by itself. Status then reads ready with bit 2 set. With T = 0, the trigger-cycle word is not kept.
- R8: In FIFO mode, words leave on the output stream in arrival order under out_ready_i backpressure. trace_ready_o is low while DEPTH words are held. Reads of address 3 return 0xFFFFFFFF and remove nothing.
- R9: A stop in FIFO mode keeps status bit 0 at 0 until the queue has drained.
- R10: Writes to the mode register while not ready are ignored.
- R11: A start (write 1 to control bit 0 while ready) clears status bits 1 and 2 and resets both pointers to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 3 | Register word address |
| wdata_i | input | 32 | Register write data |
| we_i | input | 1 | Register write enable |
| re_i | input | 1 | Read strobe; consumes a word at address 3 |
| rdata_o | output | 32 | Register read data (combinational) |
| trace_valid_i | input | 1 | Trace word valid |
| trace_data_i | input | 32 | Trace word |
| trace_ready_o | output | 1 | Trace word accepted this cycle when valid |
| trig_i | input | 1 | Trigger event |
| out_valid_o | output | 1 | FIFO-mode output valid |
| out_data_o | output | 32 | FIFO-mode output word |
| out_ready_i | input | 1 | FIFO-mode output ready |

## Verification
The bench builds the block with DEPTH = 16 and MEM_BITS = 32. With 16 entries, random captures of 1 to 40 words cross the wrap point several times. They also land exactly on DEPTH, where the full flag and the whole-buffer readout have to agree. The small depth also lets the bench fill the FIFO completely, so it can check backpressure and a stop that has to wait for the drain. The 16-byte alignment rule can be seen on a pointer write into the middle of the buffer.

// File: rtl/tcb_pkg.sv
package tcb_pkg;
  typedef enum logic [2:0] {
    REG_CTRL  = 3'd0,
    REG_MODE  = 3'd1,
    REG_TRIG  = 3'd2,
    REG_RDATA = 3'd3,
    REG_RPTR  = 3'd4,
    REG_WPTR  = 3'd5,
    REG_STAT  = 3'd6
  } reg_addr_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_CAPT  = 2'd1,
    ST_FLUSH = 2'd2
  } cap_state_e;

  typedef enum logic {
    MODE_CIRC = 1'b0,
    MODE_FIFO = 1'b1
  } cap_mode_e;
endpackage

// File: rtl/tcb_mem.sv
module tcb_mem #(
  parameter int unsigned DW    = 32,
  parameter int unsigned DEPTH = 64,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/tcb_trig.sv
module tcb_trig #(
  parameter int unsigned CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clear_i,
  input  logic          arm_i,
  input  logic          trig_i,
  input  logic          take_i,
  input  logic [CW-1:0] cnt_i,
  output logic          fired_o,
  output logic          halt_o
);
  logic          fired_q;
  logic [CW-1:0] rem_q;
  logic          fire_now;
  logic [CW-1:0] rem_eff;

  assign fire_now = fired_q | (arm_i & trig_i);
  assign rem_eff  = fired_q ? rem_q : cnt_i;
  // stop once the post-trigger budget is spent
  assign halt_o   = arm_i & fire_now & (rem_eff == '0);
  assign fired_o  = fired_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fired_q <= 1'b0;
      rem_q   <= '0;
    end else if (clear_i) begin
      fired_q <= 1'b0;
      rem_q   <= '0;
    end else if (arm_i && fire_now) begin
      fired_q <= 1'b1;
      rem_q   <= take_i ? rem_eff - 1'b1 : rem_eff;
    end
  end
endmodule

// File: rtl/tcb_ptrs.sv
module tcb_ptrs #(
  parameter int unsigned DEPTH = 64,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clear_i,
  input  logic          circ_i,
  input  logic          push_i,
  input  logic          pop_i,
  input  logic          rp_load_i,
  input  logic [AW-1:0] rp_val_i,
  output logic [AW-1:0] wp_o,
  output logic [AW-1:0] rp_o,
  output logic          full_o,
  output logic [AW:0]   avail_o
);
  localparam logic [AW:0] DEPTH_L = (AW+1)'(DEPTH);

  logic [AW-1:0] wp_q, rp_q;
  logic [AW:0]   lvl_q;
  logic          full_q, pend_q;
  logic          wrap_now;
  logic [AW-1:0] wp_nxt;

  assign wp_nxt   = wp_q + 1'b1;
  assign wrap_now = push_i & circ_i & (&wp_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q   <= '0;
      rp_q   <= '0;
      lvl_q  <= '0;
      full_q <= 1'b0;
      pend_q <= 1'b0;
    end else if (clear_i) begin
      wp_q   <= '0;
      rp_q   <= '0;
      lvl_q  <= '0;
      full_q <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      if (push_i) wp_q <= wp_nxt;
      if (wrap_now) full_q <= 1'b1;

      if (wrap_now) pend_q <= 1'b1;
      else if (pop_i || rp_load_i) pend_q <= 1'b0;

      // circular overwrite drags the oldest-word pointer along
      if (rp_load_i) rp_q <= rp_val_i;
      else if (push_i && circ_i && (full_q || wrap_now)) rp_q <= wp_nxt;
      else if (pop_i) rp_q <= rp_q + 1'b1;

      if (!circ_i) begin
        case ({push_i, pop_i})
          2'b10:   lvl_q <= lvl_q + 1'b1;
          2'b01:   lvl_q <= lvl_q - 1'b1;
          default: lvl_q <= lvl_q;
        endcase
      end
    end
  end

  assign wp_o    = wp_q;
  assign rp_o    = rp_q;
  assign full_o  = full_q;
  assign avail_o = !circ_i ? lvl_q : (pend_q ? DEPTH_L : {1'b0, wp_q - rp_q});
endmodule

// File: rtl/trace_capture_buf.sv
module trace_capture_buf
  import tcb_pkg::*;
#(
  parameter int unsigned DEPTH    = 64,
  parameter int unsigned MEM_BITS = 32,
  parameter int unsigned TRIG_W   = 16
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [2:0]  addr_i,
  input  logic [31:0] wdata_i,
  input  logic        we_i,
  input  logic        re_i,
  output logic [31:0] rdata_o,
  input  logic        trace_valid_i,
  input  logic [31:0] trace_data_i,
  output logic        trace_ready_o,
  input  logic        trig_i,
  output logic        out_valid_o,
  output logic [31:0] out_data_o,
  input  logic        out_ready_i
);
  localparam int unsigned AW  = $clog2(DEPTH);
  localparam int unsigned BW  = AW + 2;
  localparam int unsigned ALB = (MEM_BITS > 128) ? 5 : 4;
  localparam int unsigned ALW = ALB - 2;
  localparam logic [AW:0] DEPTH_L = (AW+1)'(DEPTH);

  cap_state_e        state_q, state_d;
  cap_mode_e         mode_q;
  logic [TRIG_W-1:0] trig_cnt_q;

  logic          ready, capt, circ;
  logic          start, stop_req, halt, fired;
  logic          push, pop, pop_fifo, pop_reg, rd_ok, rp_load;
  logic [AW-1:0] wp, rp, rp_val;
  logic [AW:0]   avail;
  logic          full;
  logic [31:0]   mem_rd;
  logic          cfg_wr;

  assign ready  = (state_q == ST_IDLE);
  assign capt   = (state_q == ST_CAPT);
  assign circ   = (mode_q == MODE_CIRC);
  assign cfg_wr = we_i & ready;

  assign start    = we_i && (addr_i == REG_CTRL) &&  wdata_i[0] && ready;
  assign stop_req = we_i && (addr_i == REG_CTRL) && !wdata_i[0] && capt;

  assign trace_ready_o = capt && (circ ? !halt : (avail < DEPTH_L));
  assign push          = trace_valid_i && trace_ready_o;

  assign out_valid_o = !circ && (avail != '0);
  assign out_data_o  = mem_rd;
  assign pop_fifo    = out_valid_o && out_ready_i;

  assign rd_ok   = ready && circ && (avail != '0);
  assign pop_reg = re_i && (addr_i == REG_RDATA) && rd_ok;
  assign pop     = pop_fifo | pop_reg;

  assign rp_load = cfg_wr && circ && (addr_i == REG_RPTR);
  // frame alignment: low byte-address bits dropped
  assign rp_val  = {wdata_i[BW-1:ALB], {ALW{1'b0}}};

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (start) state_d = ST_CAPT;
      ST_CAPT: begin
        if (circ && halt)  state_d = ST_IDLE;
        else if (stop_req) state_d = circ ? ST_IDLE : ST_FLUSH;
      end
      ST_FLUSH: if (avail == '0) state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      mode_q     <= MODE_CIRC;
      trig_cnt_q <= '0;
    end else begin
      state_q <= state_d;
      if (cfg_wr && addr_i == REG_MODE) mode_q <= cap_mode_e'(wdata_i[0]);
      if (cfg_wr && addr_i == REG_TRIG) trig_cnt_q <= wdata_i[TRIG_W-1:0];
    end
  end

  tcb_mem #(.DW(32), .DEPTH(DEPTH)) i_mem (
    .clk_i   (clk_i),
    .we_i    (push),
    .waddr_i (wp),
    .wdata_i (trace_data_i),
    .raddr_i (rp),
    .rdata_o (mem_rd)
  );

  tcb_ptrs #(.DEPTH(DEPTH)) i_ptrs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clear_i   (start),
    .circ_i    (circ),
    .push_i    (push),
    .pop_i     (pop),
    .rp_load_i (rp_load),
    .rp_val_i  (rp_val),
    .wp_o      (wp),
    .rp_o      (rp),
    .full_o    (full),
    .avail_o   (avail)
  );

  tcb_trig #(.CW(TRIG_W)) i_trig (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (start),
    .arm_i   (capt & circ),
    .trig_i  (trig_i),
    .take_i  (push),
    .cnt_i   (trig_cnt_q),
    .fired_o (fired),
    .halt_o  (halt)
  );

  always_comb begin
    unique case (addr_i)
      REG_CTRL:  rdata_o = {31'b0, capt};
      REG_MODE:  rdata_o = {31'b0, mode_q};
      REG_TRIG:  rdata_o = {{(32-TRIG_W){1'b0}}, trig_cnt_q};
      REG_RDATA: rdata_o = rd_ok ? mem_rd : '1;
      REG_RPTR:  rdata_o = {{(32-BW){1'b0}}, rp, 2'b00};
      REG_WPTR:  rdata_o = {{(32-BW){1'b0}}, wp, 2'b00};
      REG_STAT:  rdata_o = {29'b0, fired, full, ready};
      default:   rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/tcb_chk.sv
module tcb_chk #(
  parameter int unsigned AW  = 6,
  parameter int unsigned ALW = 2
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          ready,
  input logic          capt,
  input logic          full,
  input logic          start,
  input logic [AW-1:0] wp,
  input logic [AW-1:0] rp,
  input logic          rp_load,
  input logic          out_valid,
  input logic          circ,
  input logic          rd_ok,
  input logic [2:0]    addr,
  input logic [31:0]   rdata
);
  // R1
  ready_capt_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ready && capt));

  // R4
  wp_frozen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready && !start) |=> $stable(wp));

  // R3
  full_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full && !start) |=> full);

  // R11
  restart_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start |=> (!full && wp == '0 && rp == '0));

  // R5
  rp_align_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rp_load |=> (rp[ALW-1:0] == '0));

  // R8
  fifo_out_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid |-> !circ);

  // R2
  drained_ones_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr == 3'd3 && !rd_ok) |-> (rdata == 32'hFFFF_FFFF));
endmodule

bind trace_capture_buf tcb_chk #(.AW(AW), .ALW(ALW)) i_tcb_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .ready     (ready),
  .capt      (capt),
  .full      (full),
  .start     (start),
  .wp        (wp),
  .rp        (rp),
  .rp_load   (rp_load),
  .out_valid (out_valid_o),
  .circ      (circ),
  .rd_ok     (rd_ok),
  .addr      (addr_i),
  .rdata     (rdata_o)
);

// File: tb/test_trace_capture_buf.sv
module test_trace_capture_buf;
  localparam int DEPTH = 16;
  localparam logic [31:0] ONES = 32'hFFFF_FFFF;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic        we = 1'b0, re = 1'b0;
  logic [31:0] rdata;
  logic        tvalid = 1'b0;
  logic [31:0] tdata = '0;
  logic        tready;
  logic        trig = 1'b0;
  logic        ovalid;
  logic [31:0] odata;
  logic        oready = 1'b0;

  int vectors = 0;
  int miscompares = 0;

  always #5 clk = ~clk;

  trace_capture_buf #(.DEPTH(DEPTH), .MEM_BITS(32), .TRIG_W(16)) i_trace_capture_buf (
    .clk_i(clk), .rst_ni(rst_ni), .addr_i(addr), .wdata_i(wdata), .we_i(we), .re_i(re),
    .rdata_o(rdata), .trace_valid_i(tvalid), .trace_data_i(tdata), .trace_ready_o(tready),
    .trig_i(trig), .out_valid_o(ovalid), .out_data_o(odata), .out_ready_i(oready)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; we = 1'b1;
    @(posedge clk); #1 we = 1'b0;
  endtask

  task automatic reg_rd(input logic [2:0] a, input logic pop, output logic [31:0] d);
    @(negedge clk); addr = a; re = pop;
    #1 d = rdata;
    @(posedge clk); #1 re = 1'b0;
  endtask

  task automatic push(input logic [31:0] d, input logic t);
    @(negedge clk); tvalid = 1'b1; tdata = d; trig = t;
    @(posedge clk); #1 tvalid = 1'b0; trig = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
  endtask

  function automatic logic [31:0] wptr_exp(input int n);
    return 32'((n % DEPTH) * 4);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic [31:0] q[$];
    void'($urandom(32'd1234));
    idle(3);
    #1 rst_ni = 1'b1;

    // R1 reset state
    reg_rd(3'd6, 1'b0, d); check("R1 status", d, 32'h1);
    reg_rd(3'd1, 1'b0, d); check("R1 mode", d, 32'h0);
    reg_rd(3'd5, 1'b0, d); check("R1 wptr", d, 32'h0);
    reg_rd(3'd4, 1'b0, d); check("R1 rptr", d, 32'h0);
    reg_rd(3'd3, 1'b1, d); check("R1 rdata", d, ONES);

    // random circular captures; n=16 and n=20 forced
    for (int it = 0; it < 10; it++) begin
      int n;
      n = (it == 0) ? DEPTH : (it == 1) ? 20 : int'($urandom_range(1, 40));
      q.delete();
      reg_wr(3'd0, 32'h1);
      if (it == 2) begin
        reg_rd(3'd6, 1'b0, d); check("R11 full cleared", d, 32'h0);
        reg_rd(3'd5, 1'b0, d); check("R11 wptr cleared", d, 32'h0);
      end
      for (int k = 0; k < n; k++) begin
        logic [31:0] w;
        w = $urandom();
        idle(int'($urandom_range(0, 2)));
        push(w, 1'b0);
        q.push_back(w);
        if (q.size() > DEPTH) void'(q.pop_front());
      end
      reg_wr(3'd0, 32'h0);
      reg_rd(3'd6, 1'b0, d);
      check("R3 R4 status after stop", d, (n >= DEPTH) ? 32'h3 : 32'h1);
      reg_rd(3'd5, 1'b0, d); check("R6 wptr", d, wptr_exp(n));
      for (int k = 0; k < 3; k++) push($urandom(), 1'b0);
      reg_rd(3'd5, 1'b0, d); check("R4 wptr unchanged when stopped", d, wptr_exp(n));
      for (int k = 0; k < q.size(); k++) begin
        reg_rd(3'd3, 1'b1, d); check("R2 R3 readout", d, q[k]);
      end
      reg_rd(3'd3, 1'b1, d); check("R2 drained", d, ONES);
    end

    // R5 read pointer repositioning
    reg_wr(3'd0, 32'h1);
    for (int k = 0; k < 6; k++) push(32'd100 + 32'(k), 1'b0);
    reg_wr(3'd4, 32'h20);
    reg_rd(3'd4, 1'b0, d); check("R5 rptr write ignored while capturing", d, 32'h0);
    for (int k = 6; k < 12; k++) push(32'd100 + 32'(k), 1'b0);
    reg_wr(3'd0, 32'h0);
    reg_wr(3'd4, 32'h17);
    reg_rd(3'd4, 1'b0, d); check("R5 rptr aligned", d, 32'h10);
    for (int k = 4; k < 12; k++) begin
      reg_rd(3'd3, 1'b1, d); check("R5 readout from new rptr", d, 32'd100 + 32'(k));
    end
    reg_rd(3'd3, 1'b1, d); check("R5 drained", d, ONES);

    // R7 trigger with count 3
    reg_wr(3'd2, 32'd3);
    reg_wr(3'd0, 32'h1);
    push(32'hA0, 1'b0); push(32'hA1, 1'b0); push(32'hA2, 1'b1);
    for (int k = 3; k < 7; k++) push(32'hA0 + 32'(k), 1'b0);
    reg_rd(3'd6, 1'b0, d); check("R7 halted and triggered", d, 32'h5);
    reg_rd(3'd5, 1'b0, d); check("R7 wptr", d, 32'd20);
    for (int k = 0; k < 5; k++) begin
      reg_rd(3'd3, 1'b1, d); check("R7 readout", d, 32'hA0 + 32'(k));
    end
    reg_rd(3'd3, 1'b1, d); check("R7 drained", d, ONES);

    // R7 trigger with count 0
    reg_wr(3'd2, 32'd0);
    reg_wr(3'd0, 32'h1);
    reg_rd(3'd6, 1'b0, d); check("R11 trigger bit cleared", d, 32'h0);
    push(32'hB0, 1'b0); push(32'hB1, 1'b0); push(32'hB2, 1'b1); push(32'hB3, 1'b0);
    reg_rd(3'd5, 1'b0, d); check("R7 zero count", d, 32'd8);
    reg_rd(3'd6, 1'b0, d); check("R7 zero count status", d, 32'h5);

    // R8 R9 R10 FIFO mode
    reg_wr(3'd1, 32'h1);
    reg_wr(3'd0, 32'h1);
    reg_wr(3'd1, 32'h0);
    reg_rd(3'd1, 1'b0, d); check("R10 mode write ignored", d, 32'h1);
    for (int k = 0; k < DEPTH; k++) push(32'hC00 + 32'(k), 1'b0);
    #1 check("R8 backpressure", {31'b0, tready}, 32'h0);
    check("R8 out valid", {31'b0, ovalid}, 32'h1);
    check("R8 out head", odata, 32'hC00);
    reg_rd(3'd3, 1'b1, d); check("R8 rdata in fifo mode", d, ONES);
    reg_wr(3'd0, 32'h0);
    reg_rd(3'd6, 1'b0, d); check("R9 not ready while holding data", d[0], 1'b0);
    oready = 1'b1;
    for (int k = 0; k < DEPTH; k++) begin
      @(negedge clk);
      #1 check("R8 fifo order", odata, 32'hC00 + 32'(k));
      @(posedge clk);
    end
    #1 oready = 1'b0;
    idle(2);
    reg_rd(3'd6, 1'b0, d); check("R9 ready after drain", d[0], 1'b1);
    check("R8 out empty", {31'b0, ovalid}, 32'h0);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule